// File: doc/BRIEF.md
# OTP Packet Directory Scanner

After reset this block walks a one-time-programmable array that is organised as a chain of self-describing packets. Every packet begins with a header word. The header carries the payload length in words, so the next header lies a variable distance further on. The scanner fetches one header at a time through a request/acknowledge read port whose latency can vary. It gives consecutive packet numbers to the packets it finds and stores the start word of each one in a small on-chip directory. It also adds up the number of bytes the packets hold, counting each header and its payload.

The scan ends in one of three ways: it meets an empty header, the byte total reaches the array limit, or the directory has no free slot for a further packet. The block then raises a done flag. Client logic can then use the lookup port: it presents a packet number and, one cycle later, receives that packet's start word and a valid flag. The packet count, the byte total and an overflow flag stay on the outputs for as long as the block runs.

Top module: `otp_packet_scanner`

## Requirements
- R1: While reset is held, `scan_done`, `dir_overflow`, `packet_count`, `total_bytes` and `mem_req` are all 0. Once reset is released the scan begins without any further input.
- R2: The first header is read at word 0. After a packet whose header has size field S, the next header is read at the current word plus S+2. Packet numbers 0, 1, 2 and so on are given in address order, and each directory entry holds the word address of its packet's header.
- R3: The size field of a header is bits 15:8. Bits 31:16 and 7:0 have no effect on the scan.
- R4: A header with a size field of 0 ends the scan. It creates no packet and adds nothing to the total.
- R5: Each packet adds 4*(S+1) to `total_bytes`. When the total reaches or passes the limit (11264 bytes by default), the scan ends and no further header is read.
- R6: Once `scan_done` is 1, a lookup with an ID below `packet_count` returns valid=1 and that packet's start word one clock after the ID is presented. An ID equal to or above `packet_count` returns valid=0.
- R7: While `scan_done` is 0, every lookup returns valid=0.
- R8: If a header with a nonzero size field is read while the directory already holds DIR_DEPTH entries, the scan ends with `dir_overflow`=1. In that case no packet is created and the count and total stay unchanged.
- R9: `mem_req` stays high with `mem_addr` stable until `mem_ack` arrives. No request is made once `scan_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the scan starts when it is released |
| mem_req | output | 1 | Header read request, held until acknowledged |
| mem_addr | output | ADDR_W | Word address of the header being read |
| mem_ack | input | 1 | One-cycle acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | 32 | Header word returned by the array |
| lookup_id | input | ID_W+1 | Packet number to look up |
| lookup_valid | output | 1 | Registered: the looked-up packet exists |
| lookup_offset | output | ADDR_W | Registered: start word of the looked-up packet |
| scan_done | output | 1 | The scan has finished; stays high until reset |
| dir_overflow | output | 1 | The scan ended because the directory was full |
| packet_count | output | CNT_W | Number of packets recorded |
| total_bytes | output | TOTAL_W | Sum of header and payload bytes of the recorded packets |

## Verification
The bench builds the block with DIR_DEPTH=16 and keeps the default 11264-byte limit and 12-bit word address. The small directory means an overflow needs only seventeen short packets, and its five-bit lookup ID can carry numbers that are far beyond the count. With the default limit, eleven maximum-size packets end exactly at the limit, and a further non-empty header placed after them checks that the scan really stops there. The bench's memory model answers each request after a delay of zero to three cycles, chosen by the address, so that the wait state is exercised.

// File: rtl/otp_scan_pkg.sv
package otp_scan_pkg;

    typedef enum logic [1:0] {
        SCAN_BOOT = 2'd0,
        SCAN_WAIT = 2'd1,
        SCAN_DONE = 2'd2
    } scan_state_e;

    localparam int HDR_SIZE_LSB = 8;
    localparam int HDR_SIZE_W   = 8;

endpackage

// File: rtl/otp_dir_store.sv
module otp_dir_store #(
    parameter int DIR_DEPTH = 64,
    parameter int ADDR_W    = 12,
    localparam int ID_W     = (DIR_DEPTH > 1) ? $clog2(DIR_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ID_W-1:0]   rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [DIR_DEPTH*ADDR_W-1:0] slots_flat;

    for (genvar g = 0; g < DIR_DEPTH; g++) begin : g_slot
        logic [ADDR_W-1:0] slot_d;
        logic [ADDR_W-1:0] slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (32'(wr_idx) == g)) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            slot_q <= slot_d;
        end

        assign slots_flat[g*ADDR_W +: ADDR_W] = slot_q;
    end

    assign rd_data = slots_flat[32'(rd_idx)*ADDR_W +: ADDR_W];

endmodule

// File: rtl/otp_scan_fsm.sv
module otp_scan_fsm
    import otp_scan_pkg::*;
#(
    parameter int DIR_DEPTH   = 64,
    parameter int ADDR_W      = 12,
    parameter int LIMIT_BYTES = 11264,
    localparam int ID_W       = (DIR_DEPTH > 1) ? $clog2(DIR_DEPTH) : 1,
    localparam int CNT_W      = $clog2(DIR_DEPTH + 1),
    localparam int TOTAL_W    = $clog2(LIMIT_BYTES + 1025)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_ack,
    input  logic [HDR_SIZE_W-1:0]   hdr_size,
    output logic                    wr_en,
    output logic [ID_W-1:0]         wr_idx,
    output logic [ADDR_W-1:0]       wr_data,
    output logic                    done,
    output logic                    overflow,
    output logic [CNT_W-1:0]        count,
    output logic [TOTAL_W-1:0]      total
);

    localparam logic [TOTAL_W-1:0] LIMIT_T = TOTAL_W'(LIMIT_BYTES);
    localparam logic [CNT_W-1:0]   FULL_C  = CNT_W'(DIR_DEPTH);

    typedef struct packed {
        scan_state_e        state;
        logic [ADDR_W-1:0]  pos;
        logic [CNT_W-1:0]   count;
        logic [TOTAL_W-1:0] total;
        logic               overflow;
    } scan_regs_t;

    scan_regs_t r_d, r_q;
    logic [TOTAL_W-1:0] pkt_bytes;
    logic [ADDR_W-1:0]  step_words;

    always_comb begin
        r_d        = r_q;
        wr_en      = 1'b0;
        wr_idx     = r_q.count[ID_W-1:0];
        wr_data    = r_q.pos;
        pkt_bytes  = TOTAL_W'(({3'b000, hdr_size} + 11'd1) << 2);
        step_words = ADDR_W'({1'b0, hdr_size} + 9'd2);

        unique case (r_q.state)
            SCAN_BOOT: r_d.state = SCAN_WAIT;
            SCAN_WAIT: begin
                if (mem_ack) begin
                    if (hdr_size == '0) begin
                        r_d.state = SCAN_DONE;
                    end else if (r_q.count == FULL_C) begin
                        r_d.overflow = 1'b1;
                        r_d.state    = SCAN_DONE;
                    end else begin
                        wr_en     = 1'b1;
                        r_d.count = r_q.count + CNT_W'(1);
                        r_d.total = r_q.total + pkt_bytes;
                        r_d.pos   = r_q.pos + step_words;
                        if (r_d.total >= LIMIT_T) begin
                            r_d.state = SCAN_DONE;
                        end
                    end
                end
            end
            default: r_d.state = SCAN_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: SCAN_BOOT, pos: '0, count: '0, total: '0, overflow: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = (r_q.state == SCAN_WAIT);
    assign mem_addr = r_q.pos;
    assign done     = (r_q.state == SCAN_DONE);
    assign overflow = r_q.overflow;
    assign count    = r_q.count;
    assign total    = r_q.total;

    // R9: a pending request keeps its address until acknowledged
    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9: no header traffic after the scan has finished
    assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R8: the directory count never passes its depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C);

    // R8: the overflow flag only appears together with the end of the scan
    assert_overflow_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> done);

    // R4: an empty header finishes the scan and leaves count and total alone
    assert_empty_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && mem_req && hdr_size == '0) |=> (done && $stable(count) && $stable(total)));

    // R1: once finished the scan stays finished with frozen results
    assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(count) && $stable(total)));

endmodule

// File: rtl/otp_dir_lookup.sv
module otp_dir_lookup #(
    parameter int DIR_DEPTH = 64,
    parameter int ADDR_W    = 12,
    localparam int ID_W     = (DIR_DEPTH > 1) ? $clog2(DIR_DEPTH) : 1,
    localparam int CNT_W    = $clog2(DIR_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ID_W:0]     id_i,
    output logic [ID_W-1:0]   rd_idx_o,
    input  logic [ADDR_W-1:0] rd_data_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] offset_o
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] offset;
    } lk_regs_t;

    lk_regs_t l_d, l_q;

    always_comb begin
        rd_idx_o   = id_i[ID_W-1:0];
        l_d.valid  = done_i && (32'(id_i) < 32'(count_i));
        l_d.offset = l_d.valid ? rd_data_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign valid_o  = l_q.valid;
    assign offset_o = l_q.offset;

    // R7: nothing is valid while the scan is still running
    assert_early_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> !valid_o);

    // R6: an ID at or beyond the packet count is rejected
    assert_reject_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(id_i) >= 32'(count_i)) |=> !valid_o);

endmodule

// File: rtl/otp_packet_scanner.sv
module otp_packet_scanner
    import otp_scan_pkg::*;
#(
    parameter int DIR_DEPTH   = 64,
    parameter int ADDR_W      = 12,
    parameter int LIMIT_BYTES = 11264,
    localparam int ID_W       = (DIR_DEPTH > 1) ? $clog2(DIR_DEPTH) : 1,
    localparam int CNT_W      = $clog2(DIR_DEPTH + 1),
    localparam int TOTAL_W    = $clog2(LIMIT_BYTES + 1025)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    input  logic [ID_W:0]      lookup_id,
    output logic               lookup_valid,
    output logic [ADDR_W-1:0]  lookup_offset,
    output logic               scan_done,
    output logic               dir_overflow,
    output logic [CNT_W-1:0]   packet_count,
    output logic [TOTAL_W-1:0] total_bytes
);

    logic              wr_en;
    logic [ID_W-1:0]   wr_idx;
    logic [ADDR_W-1:0] wr_data;
    logic [ID_W-1:0]   rd_idx;
    logic [ADDR_W-1:0] rd_data;
    logic              unused_hdr_bits;

    assign unused_hdr_bits = ^{mem_rdata[31:HDR_SIZE_LSB+HDR_SIZE_W], mem_rdata[HDR_SIZE_LSB-1:0]};

    otp_scan_fsm #(
        .DIR_DEPTH  (DIR_DEPTH),
        .ADDR_W     (ADDR_W),
        .LIMIT_BYTES(LIMIT_BYTES)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mem_req (mem_req),
        .mem_addr(mem_addr),
        .mem_ack (mem_ack),
        .hdr_size(mem_rdata[HDR_SIZE_LSB +: HDR_SIZE_W]),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .done    (scan_done),
        .overflow(dir_overflow),
        .count   (packet_count),
        .total   (total_bytes)
    );

    otp_dir_store #(
        .DIR_DEPTH(DIR_DEPTH),
        .ADDR_W   (ADDR_W)
    ) store_i (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    otp_dir_lookup #(
        .DIR_DEPTH(DIR_DEPTH),
        .ADDR_W   (ADDR_W)
    ) lookup_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (scan_done),
        .count_i  (packet_count),
        .id_i     (lookup_id),
        .rd_idx_o (rd_idx),
        .rd_data_i(rd_data),
        .valid_o  (lookup_valid),
        .offset_o (lookup_offset)
    );

endmodule

// File: tb/otp_packet_scanner_tb.sv
module otp_packet_scanner_tb_top;

    localparam int DEPTH   = 16;
    localparam int AW      = 12;
    localparam int LIMIT   = 11264;
    localparam int ID_W    = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int TOTAL_W = $clog2(LIMIT + 1025);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               mem_req;
    logic [AW-1:0]      mem_addr;
    logic               mem_ack = 1'b0;
    logic [31:0]        mem_rdata = '0;
    logic [ID_W:0]      lookup_id = '0;
    logic               lookup_valid;
    logic [AW-1:0]      lookup_offset;
    logic               scan_done;
    logic               dir_overflow;
    logic [CNT_W-1:0]   packet_count;
    logic [TOTAL_W-1:0] total_bytes;

    always #10 clk = ~clk;

    otp_packet_scanner #(
        .DIR_DEPTH  (DEPTH),
        .ADDR_W     (AW),
        .LIMIT_BYTES(LIMIT)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .lookup_id    (lookup_id),
        .lookup_valid (lookup_valid),
        .lookup_offset(lookup_offset),
        .scan_done    (scan_done),
        .dir_overflow (dir_overflow),
        .packet_count (packet_count),
        .total_bytes  (total_bytes)
    );

    typedef struct {
        int    id;
        int    valid;
        int    off;
        int    stamp;
        string tag;
    } exp_t;

    exp_t        sb_q[$];
    int          vectors = 0;
    int          fails   = 0;
    int          cyc     = 0;
    int          reads   = 0;
    logic [31:0] mem [0:(1<<AW)-1];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model: acknowledge after 0..3 extra cycles chosen by the address
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && rst_n) begin
                repeat (int'(mem_addr[1:0])) @(negedge clk);
                mem_rdata = mem[mem_addr];
                mem_ack   = 1'b1;
                reads++;
            end
        end
    end

    // monitor: compare lookup results one clock after the ID was driven
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].stamp < cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " valid"}, int'(lookup_valid), e.valid);
            if (e.valid != 0) check({e.tag, " offset"}, int'(lookup_offset), e.off);
        end
    end

    task automatic drive_lookup(input int id, input int valid, input int off, input string tag);
        exp_t e;
        @(negedge clk);
        lookup_id = (ID_W+1)'(id);
        e.id = id; e.valid = valid; e.off = off; e.stamp = cyc; e.tag = tag;
        sb_q.push_back(e);
    endtask

    function automatic logic [31:0] hdr(input int size);
        return {16'hA5C3, 8'(size), 8'h5A};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < (1<<AW); i++) mem[i] = 32'hFFFF_00FF;
    endtask

    task automatic start_scan(output int base);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done in reset", int'(scan_done), 0);
        check("R1 count in reset", int'(packet_count), 0);
        check("R1 total in reset", int'(total_bytes), 0);
        check("R1 overflow in reset", int'(dir_overflow), 0);
        check("R1 req in reset", int'(mem_req), 0);
        base  = reads;
        rst_n = 1'b1;
        drive_lookup(0, 0, 0, "R7 lookup before done");
    endtask

    task automatic wait_done();
        int n = 0;
        while (!scan_done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("scan finished", int'(scan_done), 1);
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int base;
        // scenario A: sizes 3,1,7,2 then an empty header; junk in non-size bits (R3)
        clear_mem();
        mem[0]  = hdr(3);
        mem[5]  = hdr(1);
        mem[8]  = hdr(7);
        mem[17] = hdr(2);
        mem[21] = hdr(0);
        start_scan(base);
        wait_done();
        check("R4 count after empty header", int'(packet_count), 4);
        check("R5 total bytes", int'(total_bytes), 68);
        check("R8 no overflow", int'(dir_overflow), 0);
        check("R2 header reads", reads - base, 5);
        drive_lookup(0, 1, 0,  "R2 id0");
        drive_lookup(1, 1, 5,  "R2 id1");
        drive_lookup(2, 1, 8,  "R3 id2");
        drive_lookup(3, 1, 17, "R6 id3");
        drive_lookup(4, 0, 0,  "R6 id equal count");
        drive_lookup(31, 0, 0, "R6 id far beyond");
        drive_lookup(1, 1, 5,  "R6 id1 again");
        drain();

        // scenario B: empty array
        clear_mem();
        mem[0] = hdr(0);
        start_scan(base);
        wait_done();
        check("R4 empty count", int'(packet_count), 0);
        check("R4 empty total", int'(total_bytes), 0);
        check("R9 empty reads", reads - base, 1);
        drive_lookup(0, 0, 0, "R6 id0 empty");
        drain();

        // scenario C: eleven maximum packets reach the byte limit exactly
        clear_mem();
        for (int k = 0; k < 11; k++) mem[k*257] = hdr(255);
        mem[11*257] = hdr(5);
        start_scan(base);
        wait_done();
        check("R5 limit count", int'(packet_count), 11);
        check("R5 limit total", int'(total_bytes), 11264);
        check("R5 no read past limit", reads - base, 11);
        check("R5 no overflow", int'(dir_overflow), 0);
        drive_lookup(10, 1, 2570, "R2 id10 offset");
        drive_lookup(11, 0, 0,    "R6 id11 rejected");
        drain();

        // scenario D: seventeen small packets against a 16-entry directory
        clear_mem();
        for (int k = 0; k < 20; k++) mem[k*3] = hdr(1);
        start_scan(base);
        wait_done();
        check("R8 overflow flag", int'(dir_overflow), 1);
        check("R8 count at depth", int'(packet_count), 16);
        check("R8 total unchanged", int'(total_bytes), 128);
        check("R8 reads", reads - base, 17);
        drive_lookup(15, 1, 45, "R8 last entry");
        drive_lookup(16, 0, 0,  "R8 id16 rejected");
        drain();
        check("R9 no request after done", int'(mem_req), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule